// File: doc/BRIEF.md
# Carry-Corrected Bit-Serial Modular Multiplier

This block computes P = X·Y mod D for W-bit operands. It scans the multiplier Y one bit at a time, starting from the most significant bit. The accumulator is always kept to W bits. The loop never compares the accumulator with the modulus.

When a doubling or an addition carries past bit W−1, the carry is discarded and the residue R = 2^W mod D is added back. The discarded carry was worth 2^W, so adding R keeps the value congruent modulo D. If that correction carries in turn, it is repeated in the next cycle. After the last bit, one compare and conditional subtract of D brings the result into [0, D).

The modulus must have its top bit set, and X and Y must be below D. Under these conditions the accumulator stays below 2^W ≤ 2D, so a single final subtract is enough. R is normally produced on chip in a preparation phase of W steps. Each step doubles a register that starts at 1 and subtracts D when the doubled value reaches D. A caller that already knows R can supply it and skip that phase.

Top module: `modmul_carry`

## Requirements
- R1: While reset is active and in the first cycle after it is released, `busy` and `done` are low and `p` is zero.
- R2: A `start` seen while `busy` is low launches an operation, and `busy` is high in the following cycle. A `start` seen while `busy` is high is ignored: the running result is unchanged, and no second operation follows.
- R3: With d[W-1]=1, x<d and y<d, the value on `p` when `done` is high equals x·y mod d, and it is below d.
- R4: When `r_use` is high at start, `r_in` (which must equal 2^W mod d) is taken as the residue and the preparation phase is skipped. The operation then finishes exactly W cycles sooner than the same operands with `r_use` low, and gives the same result.
- R5: `done` is a single-cycle pulse, raised only after the final conditional subtraction, and `busy` is low in that cycle.
- R6: After `done`, `p` keeps its value until the next accepted `start`, whatever the other inputs do.
- R7: Carry chains, including a residue correction that itself carries, produce the correct result. Examples are d=2^W−1 with x=y=d−1, and moduli just above 2^(W−1).
- R8: A zero multiplicand or a zero multiplier gives a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch request, accepted when idle |
| x | input | W | Multiplicand, below d |
| y | input | W | Multiplier, scanned from its top bit |
| d | input | W | Modulus, top bit set |
| r_in | input | W | Caller-supplied 2^W mod d |
| r_use | input | 1 | Take r_in and skip the preparation phase |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: result valid |
| p | output | W | Result, held until the next start |

## Verification
The bound checker watches the handshake on every cycle. It checks that `done` is a lone pulse while the block is idle, that an idle start raises `busy`, that the idle result does not move, and that every delivered result is below the latched modulus. Whether that result is the right residue can only be shown by the bench's scoreboard, which compares it with x·y mod d. The same applies to the W-cycle saving from a supplied residue, to the ignored start in mid-run, and to the carry-heavy corner moduli.

// File: rtl/modmul_carry.sv
module modmul_carry #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] d,
  input  logic [W-1:0] r_in,
  input  logic         r_use,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] p
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;
  localparam logic [IW-1:0] TOP = IW'(W - 1);

  typedef enum logic [2:0] {S_IDLE, S_PREP, S_DBL, S_ADD, S_FIX, S_FIN} st_t;

  st_t           st;
  logic [W-1:0]  xq, yq, dq, rq, pq;
  logic [IW-1:0] idx;
  logic          fix_after_dbl;
  logic          done_q;

  logic [W-1:0] addend;
  logic [W:0]   sum;
  logic [W:0]   r2;
  logic         r2_ge;

  always_comb begin
    case (st)
      S_DBL:   addend = pq;
      S_ADD:   addend = yq[idx] ? xq : '0;
      default: addend = rq;
    endcase
  end

  assign sum   = {1'b0, pq} + {1'b0, addend};
  assign r2    = {rq, 1'b0};
  assign r2_ge = r2 >= {1'b0, dq};

  assign busy = (st != S_IDLE);
  assign done = done_q;
  assign p    = pq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      xq            <= '0;
      yq            <= '0;
      dq            <= '0;
      rq            <= '0;
      pq            <= '0;
      idx           <= '0;
      fix_after_dbl <= 1'b0;
      done_q        <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            xq  <= x;
            yq  <= y;
            dq  <= d;
            pq  <= '0;
            idx <= TOP;
            if (r_use) begin
              rq <= r_in;
              st <= S_DBL;
            end else begin
              rq <= W'(1);
              st <= S_PREP;
            end
          end
        end
        S_PREP: begin
          rq <= r2_ge ? (r2[W-1:0] - dq) : r2[W-1:0];
          if (idx == '0) begin
            idx <= TOP;
            st  <= S_DBL;
          end else begin
            idx <= idx - 1'b1;
          end
        end
        S_DBL: begin
          pq <= sum[W-1:0];
          if (sum[W]) begin
            fix_after_dbl <= 1'b1;
            st            <= S_FIX;
          end else begin
            st <= S_ADD;
          end
        end
        S_ADD: begin
          pq <= sum[W-1:0];
          if (sum[W]) begin
            fix_after_dbl <= 1'b0;
            st            <= S_FIX;
          end else if (idx == '0) begin
            st <= S_FIN;
          end else begin
            idx <= idx - 1'b1;
            st  <= S_DBL;
          end
        end
        S_FIX: begin
          pq <= sum[W-1:0];
          if (sum[W]) begin
            st <= S_FIX;
          end else if (fix_after_dbl) begin
            st <= S_ADD;
          end else if (idx == '0) begin
            st <= S_FIN;
          end else begin
            idx <= idx - 1'b1;
            st  <= S_DBL;
          end
        end
        S_FIN: begin
          pq     <= (pq >= dq) ? (pq - dq) : pq;
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/modmul_carry_chk.sv
module modmul_carry_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] p,
  input logic [W-1:0] dq
);
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(p));

  p_reduced_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (p < dq));
endmodule

bind modmul_carry modmul_carry_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .p(p), .dq(dq)
);

// File: tb/modmul_carry_tb.sv
module modmul_carry_tb;
  localparam int W = 8;

  typedef struct {
    int unsigned v;
    string       tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] x = '0, y = '0, d = '0, r_in = '0;
  logic         r_use = 1'b0;
  logic         busy, done;
  logic [W-1:0] p;

  int   checks = 0;
  int   fails = 0;
  bit   ended = 0;
  exp_t exp_q[$];
  int unsigned last_exp = 0;

  always #2 clk = ~clk;

  modmul_carry #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .x(x), .y(y), .d(d),
    .r_in(r_in), .r_use(r_use), .busy(busy), .done(done), .p(p)
  );

  task automatic check(input bit ok, input string tag, input int unsigned act, input int unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected done", 32'(p), 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(32'(p) == e.v, e.tag, 32'(p), e.v);
      end
    end
  end

  task automatic op(input int unsigned xv, input int unsigned yv, input int unsigned dv,
                    input bit use_r, input string tag, output int lat);
    exp_t e;
    while (busy) @(negedge clk);
    e.v = (xv * yv) % dv;
    e.tag = tag;
    last_exp = e.v;
    exp_q.push_back(e);
    x = W'(xv); y = W'(yv); d = W'(dv);
    r_in = W'((1 << W) % dv);
    r_use = use_r;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    int lat0, lat1, lt;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy in reset", 32'(busy), 0);
    check(done == 1'b0, "R1 done in reset", 32'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(p == '0, "R1 p after reset", 32'(p), 0);
    check(busy == 1'b0, "R1 busy after reset", 32'(busy), 0);

    op(5, 7, 131, 0, "R3 small", lt);
    op(200, 150, 211, 0, "R3 mid", lt);
    op(254, 254, 255, 0, "R7 all-ones modulus", lt);
    op(128, 128, 129, 0, "R7 low modulus", lt);
    op(127, 127, 128, 0, "R7 power-of-two modulus", lt);
    op(130, 129, 131, 0, "R7 near half", lt);
    op(0, 200, 251, 0, "R8 zero x", lt);
    op(123, 0, 251, 0, "R8 zero y", lt);
    op(1, 1, 128, 0, "R3 unit", lt);

    op(250, 249, 253, 0, "R4 prepared", lat0);
    op(250, 249, 253, 1, "R4 supplied", lat1);
    check(lat0 - lat1 == W, "R4 latency saving", lat0 - lat1, W);

    // start in mid-run must be ignored
    begin
      exp_t e;
      while (busy) @(negedge clk);
      e.v = (77 * 91) % 199; e.tag = "R2 ignored start";
      exp_q.push_back(e);
      x = 77; y = 91; d = 199; r_use = 0; start = 1;
      @(negedge clk); start = 0;
      repeat (4) @(negedge clk);
      x = 3; y = 3; d = 255; start = 1;
      @(negedge clk); start = 0;
      while (!done) @(negedge clk);
      @(negedge clk);
      check(busy == 1'b0, "R2 no second run", 32'(busy), 0);
      last_exp = e.v;
    end

    // result held after done
    x = 9; y = 200; d = 170;
    repeat (6) @(negedge clk);
    check(32'(p) == last_exp, "R6 hold", 32'(p), last_exp);
    check(busy == 1'b0, "R6 idle", 32'(busy), 0);

    for (int i = 0; i < 150; i++) begin
      int unsigned dv, xv, yv;
      dv = ($urandom % 128) + 128;
      xv = $urandom % dv;
      yv = $urandom % dv;
      op(xv, yv, dv, i[0], "R3 random", lt);
    end
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R5 all results delivered", exp_q.size(), 0);

    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule